// File: doc/BRIEF.md
# TDMA Clique Avoidance Checker

This block holds the membership and clique-avoidance decision for one node on a time-division bus. The bus runs a fixed schedule of `NODES` slots that repeats every round, and slot n belongs to node n. At the end of every slot the receive path gives the block a verdict on that slot's frame: silent, correct or incorrect. The block uses these verdicts to maintain a vector of the nodes it still trusts. It also keeps two tallies, one of agreement and one of disagreement, and counts only frames from trusted senders.

At the end of the slot just before the node's own slot, the block asks whether this node still sides with the majority. If it does, it raises a send grant for the node's own slot. If it does not, it blocks the send, withdraws its own membership and freezes. A frozen node stays silent and stops counting. Only an explicit re-integration request brings it back, so a persistently faulty node cannot rejoin on its own.

Top module: `clique_guard`

## Requirements
- R1: After a synchronous reset, `members` is all ones, `send_grant` is 0 and `frozen` is 0. The internal slot position is 0.
- R2: The verdict is coded as 2'b00 silent, 2'b01 correct and 2'b10 incorrect. Code 2'b11 is treated exactly like silent. Each `slot_tick` closes the current slot and advances the slot position, which wraps from `NODES-1` to 0.
- R3: An incorrect verdict on a slot owned by a current member other than `SELF_ID` clears that member's bit in `members` one cycle after the tick. No other-node bit ever returns to 1 except through reset.
- R4: Only a correct verdict from a current member other than this node adds to the agreement tally. Only an incorrect verdict from such a member adds to the disagreement tally. Silent slots and frames from non-members change neither tally.
- R5: The check runs on the tick of slot `(SELF_ID+NODES-1)%NODES` and includes that slot's own verdict. It passes when agreement is strictly greater than disagreement. A pass raises `send_grant` one cycle after the tick.
- R6: A failed check (this includes a tie) sets `frozen`, keeps `send_grant` low and clears bit `SELF_ID` of `members`, all one cycle after the tick.
- R7: `send_grant` falls one cycle after the tick of slot `SELF_ID`. If the grant was high at that tick, the node's own transmission counts as one agreement in the next round.
- R8: Both tallies clear at every check, so each round is judged only on its own slots.
- R9: While `frozen` is set, ticks change neither the tallies nor `members`, and `send_grant` stays 0. The slot position still advances.
- R10: `rejoin_req` while frozen clears `frozen`, sets bit `SELF_ID` of `members` and zeroes both tallies, one cycle later. When not frozen, `rejoin_req` has no effect.
- R11: The verdict on slot `SELF_ID` never changes `members` and never adds to either tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle pulse that closes the current slot |
| verdict | input | 2 | Receive verdict for the closing slot |
| rejoin_req | input | 1 | Re-integration request, acted on only while frozen |
| send_grant | output | 1 | Node may transmit in its own slot |
| frozen | output | 1 | Node is in a minority clique and halted |
| members | output | NODES | Current local membership vector |

## Verification
The assertions check, on every cycle, the invariants that need no memory of the round. The grant and the frozen flag are never high together. A grant only rises after the pre-own tick and falls after the own tick. Other-node membership bits never rise. Membership stays fixed while the node is frozen. Freezing removes the node's own bit, and re-integration restores it. The tally arithmetic can only be shown by the bench's scenarios: strict majority against a tie, the extra agreement from the node's own send, ignored non-member and code-11 verdicts, and counters clearing between rounds.

// File: rtl/clique_guard_pkg.sv
package clique_guard_pkg;
  typedef enum logic [1:0] {
    VD_SILENT = 2'b00,
    VD_GOOD   = 2'b01,
    VD_BAD    = 2'b10,
    VD_RSVD   = 2'b11
  } verdict_t;
endpackage

// File: rtl/cg_slot_seq.sv
module cg_slot_seq #(
  parameter int NODES   = 4,
  parameter int SELF_ID = 0,
  localparam int SW     = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [SW-1:0] slot_q,
  output logic          is_pre,
  output logic          is_own
);
  localparam int PRE_ID = (SELF_ID + NODES - 1) % NODES;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (tick) begin
      if (slot_q == SW'(NODES - 1)) slot_q <= '0;
      else                          slot_q <= slot_q + 1'b1;
    end
  end

  assign is_pre = (slot_q == SW'(PRE_ID));
  assign is_own = (slot_q == SW'(SELF_ID));

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= SW'(NODES - 1)); // R2
endmodule

// File: rtl/cg_tally.sv
module cg_tally #(
  parameter int NODES = 4,
  localparam int CW   = $clog2(NODES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic hold,
  input  logic at_pre,
  input  logic at_own,
  input  logic own_sent,
  input  logic vote_good,
  input  logic vote_bad,
  output logic pass
);
  logic [CW-1:0] acc_q, rej_q;
  logic [CW:0]   acc_sum, rej_sum;

  assign acc_sum = {1'b0, acc_q} + (CW+1)'(vote_good);
  assign rej_sum = {1'b0, rej_q} + (CW+1)'(vote_bad);
  assign pass    = acc_sum > rej_sum;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      rej_q <= '0;
    end else if (tick && !hold) begin
      if (at_own) begin
        acc_q <= own_sent ? CW'(1) : '0;
        rej_q <= '0;
      end else if (at_pre) begin
        acc_q <= '0;
        rej_q <= '0;
      end else begin
        acc_q <= acc_sum[CW-1:0];
        rej_q <= rej_sum[CW-1:0];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= CW'(NODES - 1)) && (rej_q <= CW'(NODES - 1))); // R4
  AST_CLEAR_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
    (tick && !hold && at_pre && !at_own) |=> (acc_q == '0) && (rej_q == '0)); // R8
endmodule

// File: rtl/cg_member_vec.sv
module cg_member_vec #(
  parameter int NODES   = 4,
  parameter int SELF_ID = 0,
  localparam int SW     = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drop_en,
  input  logic [SW-1:0]    drop_idx,
  input  logic             self_clear,
  input  logic             self_set,
  output logic [NODES-1:0] vec_q
);
  for (genvar i = 0; i < NODES; i++) begin : g_bit
    if (i == SELF_ID) begin : g_self
      always_ff @(posedge clk) begin
        if (rst)             vec_q[i] <= 1'b1;
        else if (self_set)   vec_q[i] <= 1'b1;
        else if (self_clear) vec_q[i] <= 1'b0;
      end
    end else begin : g_peer
      always_ff @(posedge clk) begin
        if (rst)                                  vec_q[i] <= 1'b1;
        else if (drop_en && drop_idx == SW'(i))   vec_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clique_guard.sv
module clique_guard
  import clique_guard_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int SELF_ID = 0,
  localparam int SW     = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_tick,
  input  logic [1:0]       verdict,
  input  logic             rejoin_req,
  output logic             send_grant,
  output logic             frozen,
  output logic [NODES-1:0] members
);
  logic [SW-1:0] slot_q;
  logic          is_pre, is_own, pass;
  logic          live, sender_ok, vote_good, vote_bad;
  logic          rejoin_go, check_go, freeze_go, grant_go;
  verdict_t      vd;

  assign vd        = verdict_t'(verdict);
  assign live      = slot_tick && !frozen;
  assign sender_ok = members[slot_q] && !is_own;
  assign vote_good = live && sender_ok && (vd == VD_GOOD);
  assign vote_bad  = live && sender_ok && (vd == VD_BAD);
  assign rejoin_go = rejoin_req && frozen;
  assign check_go  = live && is_pre;
  assign grant_go  = check_go && pass;
  assign freeze_go = check_go && !pass;

  cg_slot_seq #(.NODES(NODES), .SELF_ID(SELF_ID)) u_slot (
    .clk(clk), .rst(rst), .tick(slot_tick),
    .slot_q(slot_q), .is_pre(is_pre), .is_own(is_own)
  );

  cg_tally #(.NODES(NODES)) u_tally (
    .clk(clk), .rst(rst), .clr(rejoin_go), .tick(slot_tick), .hold(frozen),
    .at_pre(is_pre), .at_own(is_own), .own_sent(send_grant),
    .vote_good(vote_good), .vote_bad(vote_bad), .pass(pass)
  );

  cg_member_vec #(.NODES(NODES), .SELF_ID(SELF_ID)) u_mem (
    .clk(clk), .rst(rst), .drop_en(vote_bad), .drop_idx(slot_q),
    .self_clear(freeze_go), .self_set(rejoin_go), .vec_q(members)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen     <= 1'b0;
      send_grant <= 1'b0;
    end else begin
      if (rejoin_go)      frozen <= 1'b0;
      else if (freeze_go) frozen <= 1'b1;
      if (grant_go)                          send_grant <= 1'b1;
      else if (freeze_go || (live && is_own)) send_grant <= 1'b0;
    end
  end

  AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(send_grant && frozen)); // R6
  AST_GRANT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(send_grant) |-> $past(slot_tick && is_pre)); // R5
  AST_GRANT_FALL: assert property (@(posedge clk) disable iff (rst)
    (send_grant && slot_tick && is_own) |=> !send_grant); // R7
  AST_FREEZE_SELF: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> !members[SELF_ID]); // R6
  AST_PEER_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    ((members & ~$past(members)) & ~(NODES'(1) << SELF_ID)) == '0); // R3
  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (frozen && !rejoin_req) |=> $stable(members)); // R9
  AST_REJOIN: assert property (@(posedge clk) disable iff (rst)
    (frozen && rejoin_req) |=> (!frozen && members[SELF_ID])); // R10
endmodule

// File: tb/sim_clique_guard.sv
module sim_clique_guard;
  localparam int N   = 4;
  localparam int ME  = 2;
  localparam int PRE = (ME + N - 1) % N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         slot_tick = 1'b0;
  logic [1:0]   verdict = 2'b00;
  logic         rejoin_req = 1'b0;
  logic         send_grant, frozen;
  logic [N-1:0] members;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [N-1:0] m_mem;
  logic         m_frz, m_grant;
  int           m_acc, m_rej, m_slot;

  always #5 clk = ~clk;

  clique_guard #(.NODES(N), .SELF_ID(ME)) u0 (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .verdict(verdict),
    .rejoin_req(rejoin_req), .send_grant(send_grant), .frozen(frozen),
    .members(members)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " grant"},   int'(send_grant), int'(m_grant));
    check({tag, " frozen"},  int'(frozen),     int'(m_frz));
    check({tag, " members"}, int'(members),    int'(m_mem));
  endtask

  function automatic void model_reset();
    m_mem = '1; m_frz = 0; m_grant = 0; m_acc = 0; m_rej = 0; m_slot = 0;
  endfunction

  function automatic void model_tick(logic [1:0] v);
    int  s = m_slot;
    bit  ok = m_mem[s] && (s != ME);
    int  g = (ok && v == 2'b01) ? 1 : 0;
    int  b = (ok && v == 2'b10) ? 1 : 0;
    if (!m_frz) begin
      if (b == 1) m_mem[s] = 1'b0;
      if (s == ME) begin
        m_acc = m_grant ? 1 : 0;
        m_rej = 0;
        m_grant = 0;
      end else if (s == PRE) begin
        if (m_acc + g > m_rej + b) m_grant = 1;
        else begin
          m_frz = 1; m_grant = 0; m_mem[ME] = 1'b0;
        end
        m_acc = 0; m_rej = 0;
      end else begin
        m_acc += g; m_rej += b;
      end
    end
    m_slot = (m_slot + 1) % N;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    check("R1 grant", int'(send_grant), 0);
    check("R1 frozen", int'(frozen), 0);
    check("R1 members", int'(members), (1 << N) - 1);
  endtask

  task automatic do_tick(logic [1:0] v, string tag);
    @(negedge clk); slot_tick = 1'b1; verdict = v;
    @(negedge clk); slot_tick = 1'b0; verdict = 2'b00;
    model_tick(v);
    check_all(tag);
  endtask

  task automatic do_rejoin(string tag);
    @(negedge clk); rejoin_req = 1'b1;
    @(negedge clk); rejoin_req = 1'b0;
    if (m_frz) begin
      m_frz = 0; m_mem[ME] = 1'b1; m_acc = 0; m_rej = 0;
    end
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_c11e));
    model_reset();
    do_reset();
    // Round A: two good peers -> pass (R5), own slot drops grant (R7)
    do_tick(2'b01, "R4 good slot0");
    do_tick(2'b01, "R5 pass check");
    check("R5 grant high", int'(send_grant), 1);
    do_tick(2'b10, "R11 own verdict ignored");
    check("R11 own bit kept", int'(members[ME]), 1);
    check("R7 grant dropped", int'(send_grant), 0);
    do_tick(2'b10, "R3 bad peer dropped");
    check("R3 slot3 removed", int'(members), 4'b0111);
    // Round B: code 11 acts as silent (R2): own 1 + good 1 > bad 1
    do_tick(2'b11, "R2 code11 silent");
    do_tick(2'b01, "R7 own send counted");
    check("R7 own accept gives pass", int'(send_grant), 1);
    // Round C: non-member bad ignored (R4), two bad peers -> freeze (R6)
    do_tick(2'b01, "R7 own slot");
    do_tick(2'b10, "R4 non-member ignored");
    do_tick(2'b10, "R3 drop slot0");
    do_tick(2'b10, "R6 fail check");
    check("R6 frozen", int'(frozen), 1);
    check("R6 grant low", int'(send_grant), 0);
    check("R6 self bit", int'(members[ME]), 0);
    // Frozen: ticks ignored (R9)
    for (int i = 0; i < N; i++) do_tick(2'b01, "R9 frozen tick");
    check("R9 members held", int'(members), 0);
    do_rejoin("R10 rejoin");
    check("R10 unfrozen", int'(frozen), 0);
    do_rejoin("R10 rejoin when live ignored");
    // Tie 0 vs 0 freezes; tallies cleared by rejoin (R8)
    while (m_slot != PRE) do_tick(2'b01, "R8 walk");
    do_tick(2'b00, "R8 tie check");
    check("R8 tie freezes", int'(frozen), 1);
    // Random phase
    for (int k = 0; k < 20; k++) begin
      do_reset();
      for (int j = 0; j < 40; j++) begin
        int r = int'($urandom_range(0, 9));
        logic [1:0] v = (r < 6) ? 2'b01 : (r < 8) ? 2'b00 : (r < 9) ? 2'b10 : 2'b11;
        if (m_frz && $urandom_range(0, 3) == 0) do_rejoin("R10 random");
        else do_tick(v, "R5 random");
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule